// File: doc/BRIEF.md
# Coherency unit register bank

This block is the software-visible register bank of a multi-core coherency controller. It decodes a 256-byte window on a plain request bus that carries an 8-bit offset, separate read and write strobes, an access width given as a byte count, and 32-bit write and read data. Behind the window there are three live registers. A single-bit enable bit gates the controller. A read-only topology word describes how many cores are present. A 32-bit per-core power word can be written one byte, one half-word or one word at a time, starting at any of its four byte addresses.

Several offsets are reserved for a cache-wide invalidate command, an address-filter range and access permissions. These offsets read as zero and discard writes. Reads are combinational and are qualified by the read strobe. Writes land on the next rising clock edge. The synchronous reset clears only the enable bit. The power word starts at zero when the device powers up and keeps its value through later resets.

Top module: `cohu_regbank`

## Requirements
- R1: Offsets inside the 256-byte window that no register claims read as zero, and writes to them change no register.
- R2: A write of a valid width at offset 0x00 keeps only bit 0 of the write data as the enable bit. A read at 0x00 returns the enable bit in bit 0 and zero in bits 31:1.
- R3: Offset 0x04 is read-only. It reads NUM_CORES-1 in bits 1:0 and a 1 in bits 4 to 4+NUM_CORES-1, with zero elsewhere. With the default NUM_CORES of 1 it reads 0x10. NUM_CORES must lie in 1 to 4.
- R4: A read at offset 0x08+k, for k from 0 to 3, returns the power word shifted right by 8*k bits, with zeros filling from the top.
- R5: A write at offset 0x08+k with a width of 1, 2 or 4 bytes replaces the power-word bits under a mask of 0xFF, 0xFFFF or 0xFFFFFFFF shifted left by 8*k. The new bits come from the write data shifted left by 8*k. Mask bits that would land above bit 31 are dropped.
- R6: A write whose width code (bus_size) is not 1, 2 or 4 changes neither the enable bit nor the power word.
- R7: The reserved offsets 0x0C, 0x40, 0x44, 0x50 and 0x54 read as zero and ignore writes.
- R8: Reset clears the enable bit and leaves the power word unchanged. The power word is zero at power-up.
- R9: bus_rdata reflects the addressed register in the same cycle as bus_rd and is zero while bus_rd is low. A write is visible only after the next rising edge, and each cycle with bus_wr high performs exactly one update.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte offset inside the window |
| bus_wr | input | 1 | Write strobe, one update per cycle high |
| bus_rd | input | 1 | Read strobe, qualifies bus_rdata |
| bus_size | input | 3 | Access width as a byte count: 1, 2 or 4 |
| bus_wdata | input | 32 | Write data, right-aligned |
| bus_rdata | output | 32 | Read data, combinational |

## Verification
The assertions assume the bus inputs are known and stable from one rising edge to the next, with every strobe and offset change made between edges. The bench drives all inputs on the falling edge and compares bus_rdata one nanosecond later, well before the next rising edge. The stable-power property assumes that only a legal write to offsets 0x08 to 0x0B may move the power word. The stimulus therefore also sends writes to the topology word, the reserved offsets, offsets at the top of the window and illegal width codes, and then reads the power word back through offset 0x08.

// File: rtl/cohu_pkg.sv
package cohu_pkg;

    localparam int DATA_W = 32;
    localparam int ADDR_W = 8;
    localparam int LANES  = DATA_W / 8;

    localparam logic [ADDR_W-1:0] OFF_ENABLE = 8'h00;
    localparam logic [ADDR_W-1:0] OFF_TOPO   = 8'h04;
    localparam logic [ADDR_W-1:0] OFF_POWER  = 8'h08;
    localparam logic [ADDR_W-1:0] OFF_INVAL  = 8'h0C;
    localparam logic [ADDR_W-1:0] OFF_FLT_LO = 8'h40;
    localparam logic [ADDR_W-1:0] OFF_FLT_HI = 8'h44;
    localparam logic [ADDR_W-1:0] OFF_PERM_S = 8'h50;
    localparam logic [ADDR_W-1:0] OFF_PERM_N = 8'h54;

    typedef enum logic [2:0] {
        TGT_NONE,
        TGT_ENABLE,
        TGT_TOPO,
        TGT_POWER,
        TGT_INERT
    } cohu_tgt_e;

    typedef struct packed {
        cohu_tgt_e         tgt;
        logic [1:0]        lane;
        logic              size_ok;
        logic [DATA_W-1:0] lane_mask;
    } cohu_acc_t;

    function automatic logic width_legal(input logic [2:0] sz);
        return (sz == 3'd1) || (sz == 3'd2) || (sz == 3'd4);
    endfunction

    function automatic logic [DATA_W-1:0] width_mask(input logic [2:0] sz);
        case (sz)
            3'd1:    return 32'h0000_00FF;
            3'd2:    return 32'h0000_FFFF;
            3'd4:    return 32'hFFFF_FFFF;
            default: return '0;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] topo_word(input int cores);
        logic [DATA_W-1:0] w;
        w = '0;
        w[1:0] = 2'(cores - 1);
        for (int i = 0; i < 4; i++) begin
            if (i < cores) w[4+i] = 1'b1;
        end
        return w;
    endfunction

endpackage

// File: rtl/cohu_decode.sv
module cohu_decode
    import cohu_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic [2:0]        size,
    output cohu_acc_t         acc
);
    logic [1:0] lane;

    assign lane = addr[1:0];

    always_comb begin
        acc         = '0;
        acc.size_ok = width_legal(size);
        acc.lane    = '0;
        if (addr[ADDR_W-1:2] == OFF_POWER[ADDR_W-1:2]) begin
            acc.tgt  = TGT_POWER;
            acc.lane = lane;
        end else begin
            case (addr)
                OFF_ENABLE: acc.tgt = TGT_ENABLE;
                OFF_TOPO:   acc.tgt = TGT_TOPO;
                OFF_INVAL, OFF_FLT_LO, OFF_FLT_HI,
                OFF_PERM_S, OFF_PERM_N: acc.tgt = TGT_INERT;
                default:    acc.tgt = TGT_NONE;
            endcase
        end
        acc.lane_mask = width_mask(size) << (8 * acc.lane);
    end
endmodule

// File: rtl/cohu_power_store.sv
module cohu_power_store
    import cohu_pkg::*;
(
    input  logic              clk,
    input  logic              wr_en,
    input  logic [1:0]        lane,
    input  logic [DATA_W-1:0] lane_mask,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] status
);
    logic [DATA_W-1:0] placed;

    assign placed = wdata << (8 * lane);

    for (genvar b = 0; b < LANES; b++) begin : g_byte
        logic [7:0] byte_q = '0;
        logic       hit;

        assign hit = wr_en && lane_mask[8*b];

        always_ff @(posedge clk) begin
            if (hit) byte_q <= placed[8*b +: 8];
        end

        assign status[8*b +: 8] = byte_q;
    end
endmodule

// File: rtl/cohu_read_mux.sv
module cohu_read_mux
    import cohu_pkg::*;
(
    input  logic              rd,
    input  cohu_acc_t         acc,
    input  logic              enable_q,
    input  logic [DATA_W-1:0] topo,
    input  logic [DATA_W-1:0] status,
    output logic [DATA_W-1:0] rdata
);
    always_comb begin
        rdata = '0;
        if (rd) begin
            case (acc.tgt)
                TGT_ENABLE: rdata = {{(DATA_W-1){1'b0}}, enable_q};
                TGT_TOPO:   rdata = topo;
                TGT_POWER:  rdata = status >> (8 * acc.lane);
                default:    rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/cohu_regbank.sv
module cohu_regbank
    import cohu_pkg::*;
#(
    parameter int NUM_CORES = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [2:0]        bus_size,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata
);
    localparam logic [DATA_W-1:0] TOPO = topo_word(NUM_CORES);

    if (NUM_CORES < 1 || NUM_CORES > 4) begin : g_bad_cores
        $error("NUM_CORES must be within 1..4");
    end

    cohu_acc_t         acc;
    logic              enable_q;
    logic              pwr_wr;
    logic [DATA_W-1:0] pwr_status;

    cohu_decode u_decode (
        .addr (bus_addr),
        .size (bus_size),
        .acc  (acc)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            enable_q <= 1'b0;
        end else if (bus_wr && acc.size_ok && acc.tgt == TGT_ENABLE) begin
            enable_q <= bus_wdata[0];
        end
    end

    assign pwr_wr = bus_wr && acc.size_ok && (acc.tgt == TGT_POWER);

    cohu_power_store u_power (
        .clk       (clk),
        .wr_en     (pwr_wr),
        .lane      (acc.lane),
        .lane_mask (acc.lane_mask),
        .wdata     (bus_wdata),
        .status    (pwr_status)
    );

    cohu_read_mux u_rmux (
        .rd       (bus_rd),
        .acc      (acc),
        .enable_q (enable_q),
        .topo     (TOPO),
        .status   (pwr_status),
        .rdata    (bus_rdata)
    );
endmodule

// File: rtl/cohu_regbank_chk.sv
module cohu_regbank_chk #(
    parameter int NUM_CORES = 1
) (
    input logic        clk,
    input logic        rst,
    input logic [7:0]  bus_addr,
    input logic        bus_wr,
    input logic        bus_rd,
    input logic [2:0]  bus_size,
    input logic [31:0] bus_wdata,
    input logic [31:0] bus_rdata,
    input logic        enable_q,
    input logic [31:0] pwr_status
);
    logic [31:0] exp_topo;
    logic        legal;
    logic        pwr_addr;
    logic        mapped;

    always_comb begin
        exp_topo = 32'(((1 << NUM_CORES) - 1) << 4) | 32'(NUM_CORES - 1);
    end

    assign legal    = (bus_size == 3'd1) || (bus_size == 3'd2) || (bus_size == 3'd4);
    assign pwr_addr = (bus_addr >= 8'h08) && (bus_addr <= 8'h0B);
    assign mapped   = pwr_addr || bus_addr == 8'h00 || bus_addr == 8'h04;

    assert_reset_clears_R8: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (enable_q == 1'b0));

    assert_enable_bit0_R2: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && legal && bus_addr == 8'h00) |=> (enable_q == $past(bus_wdata[0])));

    assert_topo_value_R3: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == 8'h04) |-> (bus_rdata == exp_topo));

    assert_power_stable_R1: assert property (@(posedge clk) disable iff (rst)
        !(bus_wr && legal && pwr_addr) |=> $stable(pwr_status));

    assert_bad_width_R6: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && !legal) |=> ($stable(pwr_status) && $stable(enable_q)));

    assert_unmapped_zero_R7: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && !mapped) |-> (bus_rdata == 32'h0));

    assert_idle_zero_R9: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |-> (bus_rdata == 32'h0));

    assert_word_read_R4: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == 8'h08) |-> (bus_rdata == pwr_status));
endmodule

bind cohu_regbank cohu_regbank_chk #(.NUM_CORES(NUM_CORES)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_addr   (bus_addr),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_size   (bus_size),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .enable_q   (enable_q),
    .pwr_status (pwr_status)
);

// File: tb/cohu_regbank_tb.sv
module cohu_regbank_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [2:0]  bus_size = 3'd4;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    cohu_regbank u_dut (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_size  (bus_size),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata)
    );

    typedef struct packed {
        logic        wr;
        logic [7:0]  addr;
        logic [2:0]  size;
        logic [31:0] data;   // write data, or expected read data
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 34;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 8'h04, 3'd4, 32'h0000_0010, 8'd3},  // R3 topology word
        '{1'b1, 8'h04, 3'd4, 32'hFFFF_FFFF, 8'd3},  // R3 write ignored
        '{1'b0, 8'h04, 3'd4, 32'h0000_0010, 8'd3},  // R3
        '{1'b1, 8'h00, 3'd4, 32'hFFFF_FFFF, 8'd2},  // R2 set
        '{1'b0, 8'h00, 3'd4, 32'h0000_0001, 8'd2},  // R2 only bit 0
        '{1'b1, 8'h00, 3'd1, 32'h0000_00FE, 8'd2},  // R2 clear via byte
        '{1'b0, 8'h00, 3'd4, 32'h0000_0000, 8'd2},  // R2
        '{1'b1, 8'h08, 3'd4, 32'h1234_5678, 8'd5},  // R5 word write
        '{1'b0, 8'h08, 3'd4, 32'h1234_5678, 8'd4},  // R4 lane 0
        '{1'b0, 8'h09, 3'd4, 32'h0012_3456, 8'd4},  // R4 lane 1
        '{1'b0, 8'h0A, 3'd4, 32'h0000_1234, 8'd4},  // R4 lane 2
        '{1'b0, 8'h0B, 3'd4, 32'h0000_0012, 8'd4},  // R4 lane 3
        '{1'b1, 8'h09, 3'd1, 32'hFFFF_FFAB, 8'd5},  // R5 byte at lane 1
        '{1'b0, 8'h08, 3'd4, 32'h1234_AB78, 8'd5},  // R5
        '{1'b1, 8'h0A, 3'd2, 32'hCDEF_9999, 8'd5},  // R5 half at lane 2
        '{1'b0, 8'h08, 3'd4, 32'h9999_AB78, 8'd5},  // R5
        '{1'b1, 8'h0B, 3'd4, 32'h0000_00C3, 8'd5},  // R5 word at lane 3, top dropped
        '{1'b0, 8'h08, 3'd4, 32'hC399_AB78, 8'd5},  // R5
        '{1'b1, 8'h0A, 3'd4, 32'h1122_3344, 8'd5},  // R5 word at lane 2
        '{1'b0, 8'h0A, 3'd4, 32'h0000_3344, 8'd4},  // R4
        '{1'b1, 8'h08, 3'd3, 32'h0000_0000, 8'd6},  // R6 width 3
        '{1'b1, 8'h09, 3'd0, 32'hFFFF_FFFF, 8'd6},  // R6 width 0
        '{1'b0, 8'h08, 3'd4, 32'h3344_AB78, 8'd6},  // R6 unchanged
        '{1'b1, 8'h00, 3'd7, 32'h0000_0001, 8'd6},  // R6 enable untouched
        '{1'b0, 8'h00, 3'd4, 32'h0000_0000, 8'd6},  // R6
        '{1'b1, 8'h0C, 3'd4, 32'hFFFF_FFFF, 8'd7},  // R7 invalidate
        '{1'b1, 8'h40, 3'd4, 32'hFFFF_FFFF, 8'd7},  // R7 filter low
        '{1'b1, 8'h54, 3'd4, 32'hFFFF_FFFF, 8'd7},  // R7 permission
        '{1'b0, 8'h0C, 3'd4, 32'h0000_0000, 8'd7},  // R7
        '{1'b0, 8'h44, 3'd4, 32'h0000_0000, 8'd7},  // R7
        '{1'b0, 8'h50, 3'd4, 32'h0000_0000, 8'd7},  // R7
        '{1'b1, 8'hFC, 3'd4, 32'hFFFF_FFFF, 8'd1},  // R1 top of window
        '{1'b0, 8'hFF, 3'd4, 32'h0000_0000, 8'd1},  // R1
        '{1'b0, 8'h08, 3'd4, 32'h3344_AB78, 8'd1}   // R1 power untouched
    };

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_errors++;
            $display("FAIL %s: got %08h expected %08h", req, got, exp);
        end
    endtask

    task automatic idle();
        @(negedge clk);
        bus_wr = 1'b0;
        bus_rd = 1'b0;
    endtask

    task automatic rd_check(input logic [7:0] a, input string req, input logic [31:0] exp);
        @(negedge clk);
        bus_wr = 1'b0;
        bus_rd = 1'b1;
        bus_addr = a;
        bus_size = 3'd4;
        #1 check(req, bus_rdata, exp);
    endtask

    task automatic wr_op(input logic [7:0] a, input logic [2:0] sz, input logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b0;
        bus_wr = 1'b1;
        bus_addr = a;
        bus_size = sz;
        bus_wdata = d;
    endtask

    initial begin
        #(20 * 20000);
        if (!finished) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1 check("R9 idle read", bus_rdata, 32'h0);
        rd_check(8'h00, "R8 enable after reset", 32'h0);
        rd_check(8'h08, "R8 power at power-up", 32'h0);

        for (int i = 0; i < NV; i++) begin
            if (VECS[i].wr) begin
                wr_op(VECS[i].addr, VECS[i].size, VECS[i].data);
            end else begin
                rd_check(VECS[i].addr, $sformatf("R%0d vec %0d", VECS[i].req, i), VECS[i].data);
            end
        end

        // R9: a write is not visible before the edge, and is visible after it
        @(negedge clk);
        bus_wr = 1'b1;
        bus_rd = 1'b1;
        bus_addr = 8'h08;
        bus_size = 3'd4;
        bus_wdata = 32'hA5A5_0F0F;
        #1 check("R9 before edge", bus_rdata, 32'h3344_AB78);
        @(negedge clk);
        bus_wr = 1'b0;
        #1 check("R9 after edge", bus_rdata, 32'hA5A5_0F0F);

        // R8: reset keeps the power word and clears enable
        wr_op(8'h00, 3'd4, 32'h1);
        rd_check(8'h00, "R8 enable set", 32'h1);
        @(negedge clk);
        bus_rd = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        rd_check(8'h00, "R8 enable cleared", 32'h0);
        rd_check(8'h08, "R8 power kept", 32'hA5A5_0F0F);

        // R5: half-word at lane 3 drops bits above 31
        wr_op(8'h0B, 3'd2, 32'h0000_7E11);
        rd_check(8'h08, "R5 half at top lane", 32'h11A5_0F0F);
        idle();

        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule